// File: doc/BRIEF.md
# Critical-Word-First Block Transfer Sequencer

This block produces the order in which the 8-byte doublewords of a 256-byte cache block cross the link between the backing memory and a second-level cache. A client gives it a start pulse, a mode bit and the index of the doubleword that caused the miss. The block then emits one doubleword index per accepted cycle, with markers on the first and last transfer of the block. The data movers on both sides use those indices to address their buffers.

For a fetch, the missing doubleword leaves first. The rest of its first-level line follows, wrapping inside that line. Then the other first-level lines go out, one line at a time, starting with the line after the critical one and wrapping around the block. Within each of those lines the doublewords run upward. For a cast-out write the whole block goes out in plain ascending order from index zero.

The controller has four states. `ST_IDLE` waits for a start. `ST_CRIT` walks the critical line. `ST_REST` walks the remaining lines of a fetch. `ST_ASC` walks a write. The transitions are:
- `ST_IDLE`→`ST_CRIT` on a fetch start.
- `ST_IDLE`→`ST_ASC` on a write start.
- `ST_CRIT`→`ST_REST` when the word after the one being accepted would be the critical word again.
- `ST_REST`→`ST_IDLE` and `ST_ASC`→`ST_IDLE` when the last transfer is accepted.

The line size is a parameter. It must be a power of two that gives at least two doublewords per line and at least two lines per block.

Top module: `burst_order_seq`

## Requirements
- R1: After reset, and while no start has been taken, `valid_o` is low.
- R2: A start taken in idle with `fetch_i`=1 gives, on the next cycle, `valid_o`=1, `first_o`=1 and `idx_o` equal to the `crit_i` captured with the start.
- R3: In a fetch, transfers 2 to L (L = doublewords per line) carry the rest of the critical line: index = line base + ((critical offset + k) mod L) for k = 1..L-1, where the line is `idx_o` bits above the offset bits.
- R4: In a fetch, once the critical line is done, the other lines follow as line (critical line + m) mod N for m = 1..N-1 (N = lines per block), each from its offset 0 upward.
- R5: A start with `fetch_i`=0 gives indices 0,1,...,31 in order, whatever the value of `crit_i`.
- R6: `first_o` is high only on the first transfer and `last_o` only on the 32nd transfer of a block.
- R7: While `valid_o`=1 and `ready_i`=0, `valid_o`, `idx_o`, `first_o` and `last_o` keep their values into the next cycle.
- R8: A start, or a change of `fetch_i`/`crit_i`, while a block is in progress has no effect on the running order.
- R9: The cycle after the last transfer is accepted, `valid_o` is low and a start is taken in that same cycle.
- R10: Each block visits every one of the 32 indices exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| fetch_i | input | 1 | 1 = critical-first fetch, 0 = ascending cast-out |
| crit_i | input | 5 | Index of the critical doubleword within the block |
| ready_i | input | 1 | Consumer accepts the current index |
| valid_o | output | 1 | An index is being offered |
| idx_o | output | 5 | Doubleword index within the block |
| first_o | output | 1 | Current transfer is the first of the block |
| last_o | output | 1 | Current transfer is the last of the block |

## Verification
The bench builds two copies that share one stimulus. One copy uses the default 32-byte lines, which gives 4 doublewords in each of 8 lines. The other uses 64-byte lines, which gives 8 doublewords in each of 4 lines. A different line split moves where the critical-line wrap ends and how many lines wrap around the block, so a line-size or line-count slip shows up in one copy or the other. Critical indices at line starts, line ends and both block ends are driven directly, then random ones follow. Random stalls and starts injected mid-block exercise holding and the ignore rule.

// File: rtl/bos_pkg.sv
package bos_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CRIT,
        ST_REST,
        ST_ASC
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_HOLD,
        CMD_LOAD_FETCH,
        CMD_LOAD_WRITE,
        CMD_WORD_STEP,
        CMD_LINE_STEP
    } cur_cmd_t;

endpackage

// File: rtl/bos_ctrl.sv
module bos_ctrl
    import bos_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       fetch_i,
    input  logic       ready_i,
    input  logic       wrap_done_i,
    input  logic       line_end_i,
    input  logic       block_end_i,
    output cur_cmd_t   cmd_o,
    output logic       valid_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       adv;

    assign adv = (state_q != ST_IDLE) && ready_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = fetch_i ? ST_CRIT : ST_ASC;
                end
            end
            ST_CRIT: begin
                if (adv && wrap_done_i) begin
                    state_d = ST_REST;
                end
            end
            ST_REST, ST_ASC: begin
                if (adv && block_end_i) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        cmd_o   = CMD_HOLD;
        valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    cmd_o = fetch_i ? CMD_LOAD_FETCH : CMD_LOAD_WRITE;
                end
            end
            ST_CRIT: begin
                valid_o = 1'b1;
                if (adv) begin
                    cmd_o = wrap_done_i ? CMD_LINE_STEP : CMD_WORD_STEP;
                end
            end
            ST_REST, ST_ASC: begin
                valid_o = 1'b1;
                if (adv && !block_end_i) begin
                    cmd_o = line_end_i ? CMD_LINE_STEP : CMD_WORD_STEP;
                end
            end
        endcase
    end

    // R8: a start seen while busy must not reload the cursor
    assert_busy_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cmd_o != CMD_LOAD_FETCH && cmd_o != CMD_LOAD_WRITE));

endmodule

// File: rtl/bos_cursor.sv
module bos_cursor
    import bos_pkg::*;
#(
    parameter int WORDS      = 32,
    parameter int LINE_WORDS = 4,
    localparam int IDX_W     = $clog2(WORDS),
    localparam int LW_W      = $clog2(LINE_WORDS),
    localparam int LN_W      = IDX_W - LW_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  cur_cmd_t         cmd_i,
    input  logic [IDX_W-1:0] crit_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             first_o,
    output logic             last_o,
    output logic             wrap_done_o,
    output logic             line_end_o,
    output logic             block_end_o
);

    logic [LN_W-1:0]  line_q;
    logic [LW_W-1:0]  word_q;
    logic [LW_W-1:0]  crit_word_q;
    logic [IDX_W-1:0] cnt_q;
    logic [LW_W-1:0]  word_inc;

    assign word_inc = word_q + LW_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q      <= '0;
            word_q      <= '0;
            crit_word_q <= '0;
            cnt_q       <= '0;
        end else begin
            unique case (cmd_i)
                CMD_HOLD: begin
                end
                CMD_LOAD_FETCH: begin
                    line_q      <= crit_i[IDX_W-1:LW_W];
                    word_q      <= crit_i[LW_W-1:0];
                    crit_word_q <= crit_i[LW_W-1:0];
                    cnt_q       <= '0;
                end
                CMD_LOAD_WRITE: begin
                    line_q      <= '0;
                    word_q      <= '0;
                    crit_word_q <= '0;
                    cnt_q       <= '0;
                end
                CMD_WORD_STEP: begin
                    word_q <= word_inc;
                    cnt_q  <= cnt_q + IDX_W'(1);
                end
                CMD_LINE_STEP: begin
                    line_q <= line_q + LN_W'(1);
                    word_q <= '0;
                    cnt_q  <= cnt_q + IDX_W'(1);
                end
                default: begin
                end
            endcase
        end
    end

    assign idx_o       = {line_q, word_q};
    assign first_o     = (cnt_q == '0);
    assign block_end_o = &cnt_q;
    assign last_o      = block_end_o;
    assign line_end_o  = &word_q;
    assign wrap_done_o = (word_inc == crit_word_q);

    // R6: the transfer count never steps past the final transfer
    assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        block_end_o |-> (cmd_i != CMD_WORD_STEP && cmd_i != CMD_LINE_STEP));

    // R4: a line step always lands on offset zero of the next line
    assert_line_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_LINE_STEP) |=> (word_q == '0 && line_q == $past(line_q) + LN_W'(1)));

endmodule

// File: rtl/burst_order_seq.sv
module burst_order_seq
    import bos_pkg::*;
#(
    parameter int BLOCK_BYTES = 256,
    parameter int WORD_BYTES  = 8,
    parameter int LINE_BYTES  = 32,
    localparam int WORDS      = BLOCK_BYTES / WORD_BYTES,
    localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES,
    localparam int IDX_W      = $clog2(WORDS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             fetch_i,
    input  logic [IDX_W-1:0] crit_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             first_o,
    output logic             last_o
);

    cur_cmd_t cmd;
    logic     wrap_done;
    logic     line_end;
    logic     block_end;

    bos_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .fetch_i     (fetch_i),
        .ready_i     (ready_i),
        .wrap_done_i (wrap_done),
        .line_end_i  (line_end),
        .block_end_i (block_end),
        .cmd_o       (cmd),
        .valid_o     (valid_o)
    );

    bos_cursor #(
        .WORDS      (WORDS),
        .LINE_WORDS (LINE_WORDS)
    ) u_cursor (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .crit_i      (crit_i),
        .idx_o       (idx_o),
        .first_o     (first_o),
        .last_o      (last_o),
        .wrap_done_o (wrap_done),
        .line_end_o  (line_end),
        .block_end_o (block_end)
    );

    assert_idle_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);

    assert_fetch_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i && fetch_i) |=> (valid_o && first_o && idx_o == $past(crit_i)));

    assert_write_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i && !fetch_i) |=> (valid_o && first_o && idx_o == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(idx_o) && $stable(first_o) && $stable(last_o)));

    assert_mid_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !last_o) |=> (valid_o && !first_o));

    assert_drop_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && last_o) |=> !valid_o);

endmodule

// File: tb/burst_order_seq_bench.sv
`timescale 1ns/1ps
module burst_order_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       fetch = 1'b0;
    logic [4:0] crit = '0;
    logic       ready = 1'b0;

    logic       a_valid, a_first, a_last;
    logic [4:0] a_idx;
    logic       b_valid, b_first, b_last;
    logic [4:0] b_idx;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    burst_order_seq u_burst_order_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .fetch_i(fetch), .crit_i(crit),
        .ready_i(ready), .valid_o(a_valid), .idx_o(a_idx), .first_o(a_first), .last_o(a_last)
    );

    burst_order_seq #(.LINE_BYTES(64)) u_burst_order_seq_wide (
        .clk(clk), .rst_n(rst_n), .start_i(start), .fetch_i(fetch), .crit_i(crit),
        .ready_i(ready), .valid_o(b_valid), .idx_o(b_idx), .first_o(b_first), .last_o(b_last)
    );

    function automatic int exp_idx(bit f, int c, int n, int lw);
        int lines, m, w;
        lines = 32 / lw;
        if (!f) return n;
        if (n < lw) return (c / lw) * lw + ((c % lw + n) % lw);
        m = (n - lw) / lw + 1;
        w = (n - lw) % lw;
        return (((c / lw) + m) % lines) * lw + w;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string order_tag(bit f, int n, int lw, bit held);
        if (held) return "R7";
        if (!f) return "R5";
        if (n == 0) return "R2";
        if (n < lw) return "R3";
        return "R4";
    endfunction

    // Called at a falling edge with both copies idle.
    task automatic run_seq(bit f, int c, bit stall, bit poke);
        int n = 0;
        int guard = 0;
        bit held = 0;
        bit r;
        logic [31:0] seen_a = '0;
        logic [31:0] seen_b = '0;
        chk(a_valid == 1'b0, "R9", "idle before start (32B)", int'(a_valid), 0);
        chk(b_valid == 1'b0, "R9", "idle before start (64B)", int'(b_valid), 0);
        start = 1'b1; fetch = f; crit = 5'(c); ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        crit  = 5'($urandom);
        fetch = 1'($urandom);
        while (n < 32 && guard < 400) begin
            guard++;
            chk(a_valid == 1'b1, "R2", "valid during block (32B)", int'(a_valid), 1);
            chk(b_valid == 1'b1, "R2", "valid during block (64B)", int'(b_valid), 1);
            chk(int'(a_idx) == exp_idx(f, c, n, 4), order_tag(f, n, 4, held), "index (32B)",
                int'(a_idx), exp_idx(f, c, n, 4));
            chk(int'(b_idx) == exp_idx(f, c, n, 8), order_tag(f, n, 8, held), "index (64B)",
                int'(b_idx), exp_idx(f, c, n, 8));
            chk(a_first == (n == 0), "R6", "first marker (32B)", int'(a_first), int'(n == 0));
            chk(b_first == (n == 0), "R6", "first marker (64B)", int'(b_first), int'(n == 0));
            chk(a_last == (n == 31), "R6", "last marker (32B)", int'(a_last), int'(n == 31));
            chk(b_last == (n == 31), "R6", "last marker (64B)", int'(b_last), int'(n == 31));
            r = stall ? ($urandom % 3 != 0) : 1'b1;
            if (r) begin
                seen_a[a_idx] = 1'b1;
                seen_b[b_idx] = 1'b1;
            end
            // R8: mid-block start pulses with fresh mode and index
            start = (poke && n < 30 && ($urandom % 4 == 0));
            if (start) begin
                crit  = 5'($urandom);
                fetch = 1'($urandom);
            end
            ready = r;
            @(negedge clk);
            held = !r;
            if (r) n++;
        end
        start = 1'b0;
        ready = 1'b0;
        chk(n == 32, "R10", "transfers completed", n, 32);
        chk(a_valid == 1'b0, "R9", "valid drops after last (32B)", int'(a_valid), 0);
        chk(b_valid == 1'b0, "R9", "valid drops after last (64B)", int'(b_valid), 0);
        chk(&seen_a, "R10", "all indices visited (32B)", int'($countones(seen_a)), 32);
        chk(&seen_b, "R10", "all indices visited (64B)", int'($countones(seen_b)), 32);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R10: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset holds the outputs quiet, even with a start present
        start = 1'b1; fetch = 1'b1; crit = 5'd9;
        repeat (3) @(negedge clk);
        chk(a_valid == 1'b0, "R1", "valid in reset (32B)", int'(a_valid), 0);
        chk(b_valid == 1'b0, "R1", "valid in reset (64B)", int'(b_valid), 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(a_valid == 1'b0, "R1", "valid idle after reset (32B)", int'(a_valid), 0);
        chk(b_valid == 1'b0, "R1", "valid idle after reset (64B)", int'(b_valid), 0);

        // Directed corners: block ends, line starts and line ends
        run_seq(1'b1, 0,  1'b0, 1'b0);
        run_seq(1'b1, 31, 1'b0, 1'b0);
        run_seq(1'b1, 5,  1'b0, 1'b0);
        run_seq(1'b1, 7,  1'b0, 1'b0);
        run_seq(1'b1, 28, 1'b1, 1'b0);
        run_seq(1'b0, 13, 1'b0, 1'b0);
        run_seq(1'b0, 31, 1'b1, 1'b1);
        run_seq(1'b1, 18, 1'b1, 1'b1);

        // Random blocks
        for (int i = 0; i < 40; i++) begin
            run_seq(1'($urandom), int'($urandom % 32), 1'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule